// File: doc/BRIEF.md
# Timer Count-Clock Edge Selector

This block sits in front of a timer counter and converts one chosen count-clock source into count-enable strobes, each one clock cycle wide. The source can be an internal prescaled tick that is already synchronous to the system clock. It can also be an asynchronous external or cascaded level, which passes through a two-flop synchronizer first. An 8-bit control register holds three fields. The edge field selects whether the counter advances on rising transitions, on falling transitions or on both. The other two fields are the clear-source and prescaler selections, which the block decodes and passes on to neighbouring logic.

Only some sources honour the edge field. Flags from the source-selection logic describe the active source. For the undivided system clock and for an overflow or underflow cascaded from another channel, the edge field is ignored and the block counts rising transitions. The field is also ignored when the active internal source is not marked as divided by four or slower. When phase counting mode is active, the strobe is held low, because the phase decoder owns the counter. Software should change the register only while the counter is stopped. If it writes anyway, the new edge setting waits until the run enable next goes low.

Top module: `tcnt_edge_sel`

## Requirements
- R1: After reset the control register reads 0x00, and a write is read back unchanged on the next cycle.
- R2: The decoded outputs come from fixed register positions: clear select from bits 7..5, edge select from bits 4..3 and prescaler select from bits 2..0.
- R3: Edge code 00 on an honouring source gives one strobe for each low-to-high transition of the source and none for a high-to-low transition.
- R4: Edge code 01 on an honouring source gives one strobe for each high-to-low transition and none for a low-to-high transition.
- R5: Edge codes 10 and 11 on an honouring source give one strobe for every transition in either direction.
- R6: While the undivided-clock flag is set, every edge code behaves as code 00.
- R7: While the cascade flag is set, every edge code behaves as code 00.
- R8: The edge field is honoured only for an external source or for an internal source flagged as divided by four or slower. Any other internal source behaves as code 00.
- R9: While phase mode is active, the count-enable strobe stays low for every edge code.
- R10: A write made while run is high changes the read-back and decoded fields at once. The edge behaviour stays as it was until run has been low for at least one cycle.
- R11: An internal source's transition produces a strobe in the cycle after the first clock edge that samples it. An external source's transition produces its strobe two cycles later, and each strobe lasts exactly one cycle.
- R12: While run is low, no strobe is produced whatever the source does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write value |
| ctl_rd_data | output | 8 | Control register contents |
| run_en | input | 1 | Counter running |
| src_in | input | 1 | Level of the selected count-clock source |
| src_external | input | 1 | Source is asynchronous and is routed through the synchronizer |
| src_undiv | input | 1 | Source is the undivided system clock |
| src_cascade | input | 1 | Source is another channel's overflow/underflow |
| src_div4plus | input | 1 | Internal source is divided by four or slower |
| phase_mode | input | 1 | Phase counting mode active |
| cnt_en | output | 1 | Single-cycle count-enable strobe |
| clr_sel | output | 3 | Decoded clear-source field |
| edge_sel | output | 2 | Decoded edge-select field |
| psc_sel | output | 3 | Decoded prescaler-select field |

## Verification
A register write and a qualifying source transition can land in the same cycle while the counter runs. The write changes the edge field, and the transition must still be counted under the setting that was in force before the write. The bench provokes this by raising the source on the same clock edge that writes a falling-edge code during a rising-edge run. It then expects the rising-edge count for the whole burst together with the new field on the decoded outputs. The falling-edge count is expected only after run has been dropped and raised again. Phase mode coinciding with a qualifying transition is judged the same way: no strobe may appear.

// File: rtl/tes_pkg.sv
package tes_pkg;

  localparam int CTL_W    = 8;
  localparam int CLR_LSB  = 5;
  localparam int CLR_W    = 3;
  localparam int EDGE_LSB = 3;
  localparam int EDGE_W   = 2;
  localparam int PSC_LSB  = 0;
  localparam int PSC_W    = 3;

  typedef logic [EDGE_W-1:0] edge_code_t;

  localparam edge_code_t EDGE_RISE = 2'b00;
  localparam edge_code_t EDGE_FALL = 2'b01;

  // Edge field is honoured only for sources that are not forced to rising.
  function automatic logic edge_honored(input logic undiv, input logic cascade,
                                        input logic div4plus, input logic external);
    return !undiv && !cascade && (div4plus || external);
  endfunction

  // Code actually applied to the detector.
  function automatic edge_code_t eff_code(input logic honored, input edge_code_t code);
    return honored ? code : EDGE_RISE;
  endfunction

  // Qualifying transition for a given code; upper bit set means both directions.
  function automatic logic edge_hit(input edge_code_t code, input logic rise, input logic fall);
    if (code[1]) return rise | fall;
    else if (code[0]) return fall;
    else return rise;
  endfunction

endpackage

// File: rtl/tes_ctl_reg.sv
module tes_ctl_reg
  import tes_pkg::*;
#(
  parameter int W = CTL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             run_en,
  output logic [W-1:0]     ctl_q,
  output edge_code_t       applied_edge
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_en) ctl_q <= wr_data;
  end

  // Edge setting follows the register only while stopped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) applied_edge <= EDGE_RISE;
    else if (!run_en) applied_edge <= ctl_q[EDGE_LSB +: EDGE_W];
  end

endmodule

// File: rtl/tes_edge_det.sv
module tes_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_in,
  input  logic src_external,
  output logic rise_evt,
  output logic fall_evt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level;
  logic                   prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else sync_q[0] <= src_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  assign level = src_external ? sync_q[SYNC_STAGES-1] : src_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= level;
  end

  assign rise_evt = level & ~prev_q;
  assign fall_evt = ~level & prev_q;

endmodule

// File: rtl/tcnt_edge_sel.sv
module tcnt_edge_sel
  import tes_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr_en,
  input  logic [CTL_W-1:0]    ctl_wr_data,
  output logic [CTL_W-1:0]    ctl_rd_data,
  input  logic                run_en,
  input  logic                src_in,
  input  logic                src_external,
  input  logic                src_undiv,
  input  logic                src_cascade,
  input  logic                src_div4plus,
  input  logic                phase_mode,
  output logic                cnt_en,
  output logic [CLR_W-1:0]    clr_sel,
  output logic [EDGE_W-1:0]   edge_sel,
  output logic [PSC_W-1:0]    psc_sel
);

  logic [CTL_W-1:0] ctl_q;
  edge_code_t       applied_edge;
  edge_code_t       active_code;
  logic             honor;
  logic             rise_evt;
  logic             fall_evt;
  logic             hit;
  logic             cnt_en_q;

  tes_ctl_reg #(.W(CTL_W)) u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (ctl_wr_en),
    .wr_data      (ctl_wr_data),
    .run_en       (run_en),
    .ctl_q        (ctl_q),
    .applied_edge (applied_edge)
  );

  tes_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_in       (src_in),
    .src_external (src_external),
    .rise_evt     (rise_evt),
    .fall_evt     (fall_evt)
  );

  assign honor       = edge_honored(src_undiv, src_cascade, src_div4plus, src_external);
  assign active_code = eff_code(honor, applied_edge);
  assign hit         = edge_hit(active_code, rise_evt, fall_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_en_q <= 1'b0;
    else cnt_en_q <= run_en && !phase_mode && hit;
  end

  assign cnt_en      = cnt_en_q;
  assign ctl_rd_data = ctl_q;
  assign clr_sel     = ctl_q[CLR_LSB  +: CLR_W];
  assign edge_sel    = ctl_q[EDGE_LSB +: EDGE_W];
  assign psc_sel     = ctl_q[PSC_LSB  +: PSC_W];

endmodule

// File: rtl/tcnt_edge_sel_chk.sv
module tcnt_edge_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_en,
  input logic       phase_mode,
  input logic       src_undiv,
  input logic       src_cascade,
  input logic       cnt_en,
  input logic [1:0] applied_edge,
  input logic       honor,
  input logic       rise_evt,
  input logic       fall_evt
);

  AST_PHASE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phase_mode) |-> !cnt_en); // R9

  AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_en) |-> !cnt_en); // R12

  AST_EDGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en)) |-> $stable(applied_edge)); // R10

  AST_FORCED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && $past(src_undiv || src_cascade)) |-> $past(rise_evt)); // R6

  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && $past(honor && applied_edge == 2'b01)) |-> $past(fall_evt)); // R4

endmodule

bind tcnt_edge_sel tcnt_edge_sel_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_en       (run_en),
  .phase_mode   (phase_mode),
  .src_undiv    (src_undiv),
  .src_cascade  (src_cascade),
  .cnt_en       (cnt_en),
  .applied_edge (applied_edge),
  .honor        (honor),
  .rise_evt     (rise_evt),
  .fall_evt     (fall_evt)
);

// File: tb/tcnt_edge_sel_tb_top.sv
module tcnt_edge_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr_en = 1'b0;
  logic [7:0] ctl_wr_data = 8'h00;
  logic [7:0] ctl_rd_data;
  logic       run_en = 1'b0;
  logic       src_in = 1'b0;
  logic       src_external = 1'b0;
  logic       src_undiv = 1'b0;
  logic       src_cascade = 1'b0;
  logic       src_div4plus = 1'b0;
  logic       phase_mode = 1'b0;
  logic       cnt_en;
  logic [2:0] clr_sel;
  logic [1:0] edge_sel;
  logic [2:0] psc_sel;

  int checks = 0;
  int failures = 0;
  int pulse_cnt = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tcnt_edge_sel dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_data(ctl_rd_data), .run_en(run_en), .src_in(src_in),
    .src_external(src_external), .src_undiv(src_undiv), .src_cascade(src_cascade),
    .src_div4plus(src_div4plus), .phase_mode(phase_mode), .cnt_en(cnt_en),
    .clr_sel(clr_sel), .edge_sel(edge_sel), .psc_sel(psc_sel)
  );

  always @(negedge clk) if (cnt_en === 1'b1) pulse_cnt++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] val);
    @(negedge clk);
    ctl_wr_en = 1'b1;
    ctl_wr_data = val;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  // kind: 0 internal div4+, 1 external, 2 undivided, 3 cascade, 4 internal other, 5 phase
  task automatic set_kind(input int kind);
    src_div4plus = (kind == 0 || kind == 5);
    src_external = (kind == 1);
    src_undiv    = (kind == 2);
    src_cascade  = (kind == 3);
    phase_mode   = (kind == 5);
  endtask

  // Four low-to-high and three high-to-low transitions; source ends high.
  // Optional write lands on the same clock edge as the first rise.
  task automatic burst(input bit do_wr, input logic [7:0] wr_val);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      src_in = 1'b1;
      if (do_wr && i == 0) begin
        ctl_wr_en = 1'b1;
        ctl_wr_data = wr_val;
      end
      @(negedge clk);
      ctl_wr_en = 1'b0;
      repeat (2) @(negedge clk);
      if (i < 3) begin
        src_in = 1'b0;
        repeat (3) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic park();
    @(negedge clk);
    run_en = 1'b0;
    src_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset readback", ctl_rd_data, 0);
    chk("R1 reset cnt_en", cnt_en, 0);
    write_ctl(8'hA5);
    chk("R1 readback A5", ctl_rd_data, 8'hA5);
    chk("R2 clr A5", clr_sel, 5);
    chk("R2 edge A5", edge_sel, 0);
    chk("R2 psc A5", psc_sel, 5);
    write_ctl(8'h5A);
    chk("R2 clr 5A", clr_sel, 2);
    chk("R2 edge 5A", edge_sel, 3);
    chk("R2 psc 5A", psc_sel, 2);
  endtask

  task automatic t_case(input int code, input int kind);
    int start;
    int exp;
    bit honor;
    int eff;
    string req;
    park();
    set_kind(kind);
    write_ctl({3'b010, code[1:0], 3'b001});
    repeat (3) @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
    start = pulse_cnt;
    burst(1'b0, 8'h00);
    honor = (kind == 0 || kind == 1 || kind == 5);
    eff = honor ? code : 0;
    if (kind == 5) exp = 0;
    else if (eff >= 2) exp = 7;
    else if (eff == 1) exp = 3;
    else exp = 4;
    case (kind)
      2: req = "R6";
      3: req = "R7";
      4: req = "R8";
      5: req = "R9";
      default: req = (code == 0) ? "R3" : (code == 1) ? "R4" : "R5";
    endcase
    chk($sformatf("%s code=%0d kind=%0d", req, code, kind), pulse_cnt - start, exp);
    park();
  endtask

  task automatic t_latency(input bit ext);
    park();
    set_kind(ext ? 1 : 0);
    write_ctl(8'h00);
    repeat (3) @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
    src_in = 1'b1;
    if (!ext) begin
      @(negedge clk); chk("R11 internal strobe", cnt_en, 1);
      @(negedge clk); chk("R11 internal width", cnt_en, 0);
    end else begin
      @(negedge clk); chk("R11 external wait1", cnt_en, 0);
      @(negedge clk); chk("R11 external wait2", cnt_en, 0);
      @(negedge clk); chk("R11 external strobe", cnt_en, 1);
      @(negedge clk); chk("R11 external width", cnt_en, 0);
    end
    park();
  endtask

  task automatic t_run_write();
    int start;
    park();
    set_kind(0);
    write_ctl(8'h00);
    repeat (3) @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
    start = pulse_cnt;
    burst(1'b1, 8'h08);
    chk("R10 old rising kept", pulse_cnt - start, 4);
    chk("R10 field visible", edge_sel, 1);
    park();
    run_en = 1'b1;
    @(negedge clk);
    start = pulse_cnt;
    burst(1'b0, 8'h00);
    chk("R10 falling after stop", pulse_cnt - start, 3);
    park();
  endtask

  task automatic t_stopped();
    int start;
    park();
    set_kind(0);
    write_ctl(8'h10);
    repeat (3) @(negedge clk);
    start = pulse_cnt;
    burst(1'b0, 8'h00);
    chk("R12 run low", pulse_cnt - start, 0);
    park();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 6; k++)
        t_case(c, k);
    t_latency(1'b0);
    t_latency(1'b1);
    t_run_write();
    t_stopped();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule